// File: doc/BRIEF.md
# Per-Core Interrupt Doorbell and Mailbox Register File

This block holds the inter-processor interrupt registers for a cluster of `NCORE` cores. Every core owns a bank that holds a pending-status word, an enable word, a write-only set port, a write-only clear port and eight 32-bit mailbox words. Each core also drives one interrupt line. All banks share a single 32-bit register port. Every request carries a requester ID, and that ID picks the bank the request reaches.

Any core can ring another core by writing a doorbell word. The doorbell names a target core and a 5-bit vector number, and the block sets that bit in the target's pending status. The interrupt line is registered. It is raised only when a set or a doorbell leaves an enabled pending bit. It is lowered only when a clear empties the pending status while the enable word is nonzero. When a requester ID or a doorbell target is out of range, the block flags an error and changes nothing.

Top module: `ipi_doorbell_bank`

## Requirements
- R1: After reset, every status, enable and mailbox word reads zero, and every interrupt line is low.
- R2: Offsets 0x20 to 0x3C hold eight read/write mailbox words per core, at word index (offset-0x20)>>2. Each core's words are independent of the other cores' words.
- R3: A write to status (0x00) leaves status unchanged. Reads of set (0x08) and clear (0x0C) return zero. Reads of unmapped offsets from 0x44 upward return zero and raise no error. Only the 8-bit offset is decoded.
- R4: A set write (0x08) ORs its data into status. The line rises one cycle later if the new status ANDed with enable is nonzero. Otherwise the line keeps its value.
- R5: A clear write (0x0C) removes the written bits from status. The line falls one cycle later only if the new status is zero and enable is nonzero. Otherwise the line keeps its value.
- R6: An enable write (0x04) updates enable and never changes the interrupt line.
- R7: A doorbell write (0x40) takes its target core from data bits 25:16 and its vector from bits 4:0. It sets bit `vector` of the target's status and applies the raise rule of R4 to the target's line.
- R8: A request whose requester ID is not below `NCORE` asserts `rsp_err` in the same cycle, returns zero data and changes no state.
- R9: A doorbell write whose target is not below `NCORE` asserts `rsp_err` and changes no state.
- R10: Read data is combinational and valid in the cycle of the request. Writes return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_id | input | IDW | Requester core ID, selects the bank |
| req_addr | input | 8 | Byte offset inside the bank |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, same cycle |
| rsp_err | output | 1 | Decode error, same cycle |
| irq | output | NCORE | Registered interrupt line per core |

## Verification
A corrupted status or enable word shows up in one of two ways. It changes the value returned when that bank is read in the same cycle, or it changes the interrupt line one cycle after the next set, clear or doorbell to that core. For that reason, every write in the sweeps is followed by a check of the interrupt lines on the next cycle. A lost mailbox or status bit shows up on the first read-back of that bank. A doorbell decoded to the wrong core shows up as a line and a status bit on an innocent core.

// File: rtl/ipi_doorbell_bank.sv
module ipi_doorbell_bank #(
  parameter int NCORE = 4,
  parameter int IDW   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [IDW-1:0]   req_id,
  input  logic [7:0]       req_addr,
  input  logic [31:0]      req_wdata,
  output logic [31:0]      rsp_rdata,
  output logic             rsp_err,
  output logic [NCORE-1:0] irq
);
  localparam int CW   = (NCORE > 1) ? $clog2(NCORE) : 1;
  localparam int NBOX = 8;

  logic [NCORE-1:0][31:0]           status_q, enable_q;
  logic [NCORE-1:0][NBOX-1:0][31:0] box_q;

  wire [9:0]    tgt     = req_wdata[25:16];
  wire          id_ok   = 32'(req_id) < NCORE;
  wire          tgt_ok  = 32'(tgt) < NCORE;
  wire          is_bell = req_addr == 8'h40;
  wire          is_box  = req_addr[7:5] == 3'b001;
  wire [CW-1:0] cid     = req_id[CW-1:0];
  wire [CW-1:0] tid     = tgt[CW-1:0];
  wire [2:0]    widx    = req_addr[4:2];

  assign rsp_err = req_valid && (!id_ok || (req_write && is_bell && !tgt_ok));
  wire   wr      = req_valid && req_write && !rsp_err;

  always_comb begin
    rsp_rdata = '0;
    if (req_valid && !req_write && id_ok) begin
      if (is_box) rsp_rdata = box_q[cid][widx];
      else if (req_addr == 8'h00) rsp_rdata = status_q[cid];
      else if (req_addr == 8'h04) rsp_rdata = enable_q[cid];
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    wire        own   = wr && (cid == CW'(c));
    wire        sethw = own && req_addr == 8'h08;
    wire        bell  = wr && is_bell && (tid == CW'(c));
    wire        clr   = own && req_addr == 8'h0C;
    wire [31:0] setm  = (sethw ? req_wdata : 32'd0) | (bell ? (32'd1 << req_wdata[4:0]) : 32'd0);
    wire [31:0] nxt   = clr ? (status_q[c] & ~req_wdata) : (status_q[c] | setm);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        status_q[c] <= '0;
        enable_q[c] <= '0;
        box_q[c]    <= '0;
        irq[c]      <= 1'b0;
      end else begin
        status_q[c] <= nxt;
        if (own && req_addr == 8'h04) enable_q[c] <= req_wdata;
        if (own && is_box) box_q[c][widx] <= req_wdata;
        if ((sethw || bell) && (nxt & enable_q[c]) != 0) irq[c] <= 1'b1;
        else if (clr && nxt == 0 && enable_q[c] != 0) irq[c] <= 1'b0;
      end
    end
  end
endmodule

module ipi_doorbell_bank_chk #(
  parameter int NCORE = 4,
  parameter int IDW   = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_write,
  input logic [7:0]             req_addr,
  input logic                   rsp_err,
  input logic [NCORE-1:0]       irq,
  input logic [NCORE-1:0][31:0] status_q
);
  wire okw = req_valid && req_write && !rsp_err;

  p_err_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |=> $stable(status_q) && $stable(irq));
  p_enable_keeps_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (okw && req_addr == 8'h04) |=> $stable(irq));
  p_status_readonly_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (okw && req_addr == 8'h00) |=> $stable(status_q));
  p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~$past(irq)) != 0) |-> $past(okw && (req_addr == 8'h08 || req_addr == 8'h40)));
  p_fall_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~irq & $past(irq)) != 0) |-> $past(okw && req_addr == 8'h0C));
endmodule

bind ipi_doorbell_bank ipi_doorbell_bank_chk #(.NCORE(NCORE), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_err(rsp_err), .irq(irq), .status_q(status_q));

// File: tb/ipi_doorbell_bank_test.sv
module ipi_doorbell_bank_test;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [9:0] req_id = 0;
  logic [7:0] req_addr = 0;
  logic [31:0] req_wdata = 0, rsp_rdata;
  logic rsp_err;
  logic [N-1:0] irq;
  int nvec = 0, nbad = 0;

  logic [31:0] m_st [N], m_en [N], m_mb [N][8];
  logic [N-1:0] m_irq;

  always #2 clk = ~clk;

  ipi_doorbell_bank #(.NCORE(N), .IDW(10)) uut (.*);

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic op(string r, bit w, int id, int a, logic [31:0] d);
    bit er;
    logic [31:0] rd;
    int t;
    @(negedge clk);
    req_valid = 1; req_write = w; req_id = 10'(id); req_addr = 8'(a); req_wdata = d;
    t = int'(d[25:16]);
    er = (id >= N) || (w && a == 'h40 && t >= N);
    rd = 0;
    if (!w && !er) begin
      if (a == 0) rd = m_st[id];
      else if (a == 4) rd = m_en[id];
      else if (a >= 'h20 && a <= 'h3C) rd = m_mb[id][(a - 'h20) >> 2];
    end
    #1;
    chk({r, " err"}, 32'(rsp_err), 32'(er));
    chk({r, " rdata"}, rsp_rdata, rd);
    @(posedge clk);
    if (w && !er) begin
      if (a == 4) m_en[id] = d;
      else if (a == 8) begin
        m_st[id] |= d;
        if ((m_st[id] & m_en[id]) != 0) m_irq[id] = 1;
      end else if (a == 'hC) begin
        m_st[id] &= ~d;
        if (m_st[id] == 0 && m_en[id] != 0) m_irq[id] = 0;
      end else if (a >= 'h20 && a <= 'h3C) m_mb[id][(a - 'h20) >> 2] = d;
      else if (a == 'h40) begin
        m_st[t] |= 32'd1 << d[4:0];
        if ((m_st[t] & m_en[t]) != 0) m_irq[t] = 1;
      end
    end
    #1;
    chk({r, " irq"}, 32'(irq), 32'(m_irq));
  endtask

  initial begin
    #400000;
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    m_irq = 0;
    for (int c = 0; c < N; c++) begin
      m_st[c] = 0; m_en[c] = 0;
      for (int w = 0; w < 8; w++) m_mb[c][w] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk("R1 irq", 32'(irq), 0);
    for (int c = 0; c < N; c++)
      for (int a = 0; a < 'h48; a += 4) op("R1 reset read", 0, c, a, 0);

    for (int c = 0; c < N; c++)
      for (int w = 0; w < 8; w++) op("R2 mbox write", 1, c, 'h20 + 4*w, {8'(c), 8'(w), 16'hA5C3 ^ 16'(c*8+w)});
    for (int c = 0; c < N; c++)
      for (int w = 0; w < 8; w++) op("R2 mbox read", 0, c, 'h20 + 4*w, 0);

    op("R3 status write", 1, 1, 0, 32'hFFFF_FFFF);
    op("R3 status read", 0, 1, 0, 0);
    op("R3 set read", 0, 1, 8, 0);
    op("R3 clear read", 0, 1, 'hC, 0);
    for (int a = 'h44; a < 256; a += 4) op("R3 unmapped read", 0, 2, a, 0);
    op("R3 unmapped write", 1, 2, 'h80, 32'h1234);

    for (int c = 0; c < N; c++) begin
      logic [31:0] ens [4] = '{32'h0, 32'h1, 32'h8000_0001, 32'h0000_00F0};
      foreach (ens[e]) begin
        op("R6 enable write", 1, c, 4, ens[e]);
        op("R4 set", 1, c, 8, 32'h1);
        op("R4 set", 1, c, 8, 32'h10);
        op("R4 set", 1, c, 8, 32'h8000_0000);
        op("R4 status read", 0, c, 0, 0);
        op("R5 clear partial", 1, c, 'hC, 32'h1);
        op("R5 clear rest", 1, c, 'hC, 32'hFFFF_FFFF);
        op("R5 status read", 0, c, 0, 0);
      end
      op("R6 disable", 1, c, 4, 0);
      op("R4 set masked", 1, c, 8, 32'h6);
      op("R6 enable no raise", 1, c, 4, 32'h6);
      op("R4 set zero raises", 1, c, 8, 0);
      op("R6 disable keeps line", 1, c, 4, 0);
      op("R5 clear enable zero", 1, c, 'hC, 32'hFFFF_FFFF);
      op("R5 enable", 1, c, 4, 32'h1);
      op("R5 clear lowers", 1, c, 'hC, 0);
    end

    for (int c = 0; c < N; c++) op("R7 enable", 1, c, 4, 32'h0000_FFFF);
    for (int s = 0; s < N; s++)
      for (int t = 0; t < N; t++)
        for (int v = 0; v < 32; v++) begin
          op("R7 bell", 1, s, 'h40, {6'd0, 10'(t), 11'd0, 5'(v)});
          if (v % 8 == 7) op("R7 status read", 0, t, 0, 0);
          if (v == 31) op("R7 clear", 1, t, 'hC, 32'hFFFF_FFFF);
        end

    op("R8 mark", 1, 0, 8, 32'h3);
    for (int id = N; id < N + 4; id++) begin
      op("R8 bad id read", 0, id, 0, 0);
      op("R8 bad id set", 1, id, 8, 32'hFFFF_FFFF);
      op("R8 bad id mbox", 1, id, 'h20, 32'hDEAD);
    end
    op("R8 bad id max", 1, 1023, 'hC, 32'hFFFF_FFFF);
    op("R8 status kept", 0, 0, 0, 0);
    op("R9 bad target", 1, 1, 'h40, {6'd0, 10'(N), 16'd3});
    op("R9 bad target max", 1, 2, 'h40, {6'd0, 10'd1023, 16'd9});
    for (int c = 0; c < N; c++) op("R9 status kept", 0, c, 0, 0);
    op("R10 write data zero", 1, 0, 0, 0);

    @(negedge clk); req_valid = 0;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule